// File: doc/BRIEF.md
# Accumulator ALU with Flag Update Rules

This block is the arithmetic and logic unit of a small accumulator processor. Each cycle it takes an operation code, two operands (A and B) and the current negative, overflow, zero, carry and decimal flags. One clock later it presents the result, four updated flags and a write enable for the result and for each flag. The surrounding register file stores only what is enabled, so every operation class changes exactly its own subset of flags.

Unary operations work on operand B: increment, decrement, the four shifts and rotates, and pass-through. The caller routes memory data, A, X or Y onto B as needed. Add and subtract with carry switch from binary to packed BCD when the decimal flag is set. Compare always works in binary. Operand width is four bits per decimal digit, set by the `DIGITS` parameter; the default is two digits (8 bits).

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to 0 at that edge.
- R2: Outputs change only at a rising clock edge. They reflect the inputs sampled at that edge, so results appear one cycle after the inputs.
- R3: Codes 0 (OR), 1 (AND) and 2 (XOR) produce the bitwise A|B, A&B and A^B. They enable the result, N and Z only.
- R4: Code 3 (add with carry, D=0) produces A+B+C modulo 2^W. C is the carry out. V is set when A and B have the same sign and the result sign differs. Result, N, V, Z and C are all enabled.
- R5: Code 4 (subtract with carry, D=0) produces A+~B+C. After it, C=1 means no borrow. V follows the R4 rule with ~B in place of B. All four flags and the result are enabled.
- R6: With D=1 and valid packed BCD operands, code 3 gives the decimal sum of A, B and C. Code 4 gives the decimal difference A-B-(1-C). C is the decimal carry, or no-borrow, out of the top digit. V keeps its binary value from R4 or R5.
- R7: Code 5 (compare) evaluates A-B in binary, ignoring D and the carry input. C=1 when A>=B unsigned, Z=1 when A==B, and N is the top bit of the difference. Only N, Z and C are enabled; the result write enable is 0 and the result output is 0.
- R8: Code 6 (bit test) sets Z when A&B is zero, and copies B's top bit into N and the next bit into V. Only N, V and Z are enabled; the result write enable is 0 and the result output is 0.
- R9: Codes 7 (increment) and 8 (decrement) produce B+1 and B-1 modulo 2^W. They enable the result, N and Z only.
- R10: Codes 9 to 12 shift B one place and put the bit shifted out into C. Code 9 shifts left with a 0 fill, code 10 rotates left through C, code 11 shifts right with a 0 fill, and code 12 rotates right through C. Result, N, Z and C are enabled.
- R11: Code 13 (pass) outputs B and enables the result, N and Z only.
- R12: For every operation that enables the result, N equals the top result bit and Z is 1 exactly when the result is 0.
- R13: A flag whose write enable is 0 shows its input value unchanged. Codes 14 and 15 enable nothing and output a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 4*DIGITS | Operand A (accumulator or compare register) |
| b_i | input | 4*DIGITS | Operand B (memory data or source register) |
| n_i | input | 1 | Current negative flag |
| v_i | input | 1 | Current overflow flag |
| z_i | input | 1 | Current zero flag |
| c_i | input | 1 | Current carry flag |
| d_i | input | 1 | Decimal mode flag |
| res_o | output | 4*DIGITS | Registered result |
| res_we_o | output | 1 | Result write enable |
| n_o | output | 1 | Next negative flag |
| v_o | output | 1 | Next overflow flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| n_we_o | output | 1 | Negative flag write enable |
| v_we_o | output | 1 | Overflow flag write enable |
| z_we_o | output | 1 | Zero flag write enable |
| c_we_o | output | 1 | Carry flag write enable |

## Verification
The bench builds the block with `DIGITS=1`, a single 4-bit digit. This makes an exhaustive sweep practical: every operation code against every pair of operands, with all four carry/decimal combinations and varied incoming N, V and Z values. At that width, every binary carry and overflow case, every decimal digit correction and borrow, and every shift fill value is exercised. The same generate loop that builds one digit in the bench builds each digit at the default width.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    ALU_OR   = 4'd0,
    ALU_AND  = 4'd1,
    ALU_XOR  = 4'd2,
    ALU_ADC  = 4'd3,
    ALU_SBC  = 4'd4,
    ALU_CMP  = 4'd5,
    ALU_BIT  = 4'd6,
    ALU_INC  = 4'd7,
    ALU_DEC  = 4'd8,
    ALU_ASL  = 4'd9,
    ALU_ROL  = 4'd10,
    ALU_LSR  = 4'd11,
    ALU_ROR  = 4'd12,
    ALU_PASS = 4'd13,
    ALU_RSV0 = 4'd14,
    ALU_RSV1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flag4_t;

endpackage

// File: rtl/acc_alu_bcd.sv
// Packed BCD add/subtract: one corrected digit per generate slice,
// carry (add) or borrow (subtract) rippling between digits.
module acc_alu_bcd #(
  parameter int DIGITS = 2
) (
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  input  logic                sub_i,
  input  logic                cin_i,
  output logic [4*DIGITS-1:0] sum_o,
  output logic                cout_o
);

  logic [DIGITS:0] chain;

  assign chain[0] = sub_i ? ~cin_i : cin_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] ad;
    logic [3:0] bd;
    logic [4:0] t;
    logic [3:0] r;
    logic       k;

    assign ad = a_i[4*g +: 4];
    assign bd = b_i[4*g +: 4];

    always_comb begin
      if (sub_i) begin
        t = {1'b0, ad} - {1'b0, bd} - {4'b0000, chain[g]};
        k = t[4];
        r = k ? (t[3:0] - 4'd6) : t[3:0];
      end else begin
        t = {1'b0, ad} + {1'b0, bd} + {4'b0000, chain[g]};
        k = (t > 5'd9);
        r = k ? (t[3:0] + 4'd6) : t[3:0];
      end
    end

    assign sum_o[4*g +: 4] = r;
    assign chain[g+1]      = k;
  end

  assign cout_o = sub_i ? ~chain[DIGITS] : chain[DIGITS];

endmodule

// File: rtl/acc_alu_arith.sv
// Binary adder with inverted-operand subtract, plus decimal path selection.
module acc_alu_arith #(
  parameter int DIGITS = 2
) (
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  input  logic                cin_i,
  input  logic                sub_i,
  input  logic                dec_i,
  output logic [4*DIGITS-1:0] res_o,
  output logic                c_o,
  output logic                v_o
);

  localparam int W = 4 * DIGITS;

  logic [W-1:0] b_eff;
  logic [W-1:0] bin_sum;
  logic [W-1:0] dec_sum;
  logic         bin_c;
  logic         dec_c;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign {bin_c, bin_sum} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};

  // signed overflow of the binary sum, kept in decimal mode too
  assign v_o = (a_i[W-1] == b_eff[W-1]) && (bin_sum[W-1] != a_i[W-1]);

  acc_alu_bcd #(.DIGITS(DIGITS)) u_bcd (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_i),
    .cin_i  (cin_i),
    .sum_o  (dec_sum),
    .cout_o (dec_c)
  );

  assign res_o = dec_i ? dec_sum : bin_sum;
  assign c_o   = dec_i ? dec_c   : bin_c;

endmodule

// File: rtl/acc_alu_logic.sv
// Bitwise, unary and shift operations.
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  alu_op_e             op_i,
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  input  logic                cin_i,
  output logic [4*DIGITS-1:0] res_o,
  output logic                c_o
);

  localparam int W = 4 * DIGITS;

  always_comb begin
    res_o = b_i;
    c_o   = cin_i;
    unique case (op_i)
      ALU_OR:  res_o = a_i | b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_XOR: res_o = a_i ^ b_i;
      ALU_INC: res_o = b_i + W'(1);
      ALU_DEC: res_o = b_i - W'(1);
      ALU_ASL: begin
        res_o = {b_i[W-2:0], 1'b0};
        c_o   = b_i[W-1];
      end
      ALU_ROL: begin
        res_o = {b_i[W-2:0], cin_i};
        c_o   = b_i[W-1];
      end
      ALU_LSR: begin
        res_o = {1'b0, b_i[W-1:1]};
        c_o   = b_i[0];
      end
      ALU_ROR: begin
        res_o = {cin_i, b_i[W-1:1]};
        c_o   = b_i[0];
      end
      default: res_o = b_i;
    endcase
  end

endmodule

// File: rtl/acc_alu_select.sv
// Chooses the result source and the per-class flag subset.
module acc_alu_select
  import acc_alu_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  alu_op_e             op_i,
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  input  flag4_t              flg_i,
  input  logic [4*DIGITS-1:0] lres_i,
  input  logic                lc_i,
  input  logic [4*DIGITS-1:0] ares_i,
  input  logic                ac_i,
  input  logic                av_i,
  output logic [4*DIGITS-1:0] res_o,
  output logic                res_we_o,
  output flag4_t              flg_o,
  output flag4_t              we_o
);

  localparam int W = 4 * DIGITS;

  logic [W-1:0] masked;
  assign masked = a_i & b_i;

  always_comb begin
    res_o    = '0;
    res_we_o = 1'b0;
    flg_o    = flg_i;
    we_o     = '0;
    unique case (op_i)
      ALU_OR, ALU_AND, ALU_XOR, ALU_INC, ALU_DEC, ALU_PASS: begin
        res_o    = lres_i;
        res_we_o = 1'b1;
        we_o.n   = 1'b1;
        we_o.z   = 1'b1;
      end
      ALU_ADC, ALU_SBC: begin
        res_o    = ares_i;
        res_we_o = 1'b1;
        flg_o.v  = av_i;
        flg_o.c  = ac_i;
        we_o     = 4'b1111;
      end
      ALU_CMP: begin
        flg_o.n = ares_i[W-1];
        flg_o.z = (ares_i == '0);
        flg_o.c = ac_i;
        we_o.n  = 1'b1;
        we_o.z  = 1'b1;
        we_o.c  = 1'b1;
      end
      ALU_BIT: begin
        flg_o.n = b_i[W-1];
        flg_o.v = b_i[W-2];
        flg_o.z = (masked == '0);
        we_o.n  = 1'b1;
        we_o.v  = 1'b1;
        we_o.z  = 1'b1;
      end
      ALU_ASL, ALU_ROL, ALU_LSR, ALU_ROR: begin
        res_o    = lres_i;
        res_we_o = 1'b1;
        flg_o.c  = lc_i;
        we_o.n   = 1'b1;
        we_o.z   = 1'b1;
        we_o.c   = 1'b1;
      end
      default: ;
    endcase
    if (res_we_o) begin
      flg_o.n = res_o[W-1];
      flg_o.z = (res_o == '0);
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          op_i,
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  input  logic                n_i,
  input  logic                v_i,
  input  logic                z_i,
  input  logic                c_i,
  input  logic                d_i,
  output logic [4*DIGITS-1:0] res_o,
  output logic                res_we_o,
  output logic                n_o,
  output logic                v_o,
  output logic                z_o,
  output logic                c_o,
  output logic                n_we_o,
  output logic                v_we_o,
  output logic                z_we_o,
  output logic                c_we_o
);

  localparam int W = 4 * DIGITS;

  alu_op_e      op;
  flag4_t       flg_in;
  logic         is_sub;
  logic         arith_cin;
  logic         arith_dec;
  logic [W-1:0] lres;
  logic         lc;
  logic [W-1:0] ares;
  logic         ac;
  logic         av;
  logic [W-1:0] nxt_res;
  logic         nxt_res_we;
  flag4_t       nxt_flg;
  flag4_t       nxt_we;
  logic         live;

  assign op        = alu_op_e'(op_i);
  assign flg_in    = '{n: n_i, v: v_i, z: z_i, c: c_i};
  assign is_sub    = (op == ALU_SBC) || (op == ALU_CMP);
  assign arith_cin = (op == ALU_CMP) ? 1'b1 : c_i;
  assign arith_dec = d_i && ((op == ALU_ADC) || (op == ALU_SBC));

  acc_alu_arith #(.DIGITS(DIGITS)) u_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (arith_cin),
    .sub_i (is_sub),
    .dec_i (arith_dec),
    .res_o (ares),
    .c_o   (ac),
    .v_o   (av)
  );

  acc_alu_logic #(.DIGITS(DIGITS)) u_logic (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (c_i),
    .res_o (lres),
    .c_o   (lc)
  );

  acc_alu_select #(.DIGITS(DIGITS)) u_sel (
    .op_i     (op),
    .a_i      (a_i),
    .b_i      (b_i),
    .flg_i    (flg_in),
    .lres_i   (lres),
    .lc_i     (lc),
    .ares_i   (ares),
    .ac_i     (ac),
    .av_i     (av),
    .res_o    (nxt_res),
    .res_we_o (nxt_res_we),
    .flg_o    (nxt_flg),
    .we_o     (nxt_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o    <= '0;
      res_we_o <= 1'b0;
      n_o      <= 1'b0;
      v_o      <= 1'b0;
      z_o      <= 1'b0;
      c_o      <= 1'b0;
      n_we_o   <= 1'b0;
      v_we_o   <= 1'b0;
      z_we_o   <= 1'b0;
      c_we_o   <= 1'b0;
      live     <= 1'b0;
    end else begin
      res_o    <= nxt_res;
      res_we_o <= nxt_res_we;
      n_o      <= nxt_flg.n;
      v_o      <= nxt_flg.v;
      z_o      <= nxt_flg.z;
      c_o      <= nxt_flg.c;
      n_we_o   <= nxt_we.n;
      v_we_o   <= nxt_we.v;
      z_we_o   <= nxt_we.z;
      c_we_o   <= nxt_we.c;
      live     <= 1'b1;
    end
  end

  // R4: binary add result and carry match the full-width sum
  a_r4_binary_sum: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_i) == ALU_ADC && !$past(d_i)) |->
      ({c_o, res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{W{1'b0}}, $past(c_i)})));

  // R7: compare writes no result and leaves V alone
  a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_i) == ALU_CMP) |->
      (!res_we_o && !v_we_o && v_o == $past(v_i) && c_we_o));

  // R8: bit test copies the two top operand bits
  a_r8_bit_copy: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_i) == ALU_BIT) |->
      (n_o == $past(b_i[W-1]) && v_o == $past(b_i[W-2]) && !res_we_o && !c_we_o));

  // R9: increment/decrement keep V and C
  a_r9_incdec_keep_vc: assert property (@(posedge clk) disable iff (rst)
    (live && ($past(op_i) == ALU_INC || $past(op_i) == ALU_DEC)) |->
      (!v_we_o && !c_we_o && v_o == $past(v_i) && c_o == $past(c_i)));

  // R12: N and Z follow a written result
  a_r12_nz_follow: assert property (@(posedge clk) disable iff (rst)
    (live && res_we_o) |-> (n_o == res_o[W-1] && z_o == (res_o == '0)));

  // R13: an unwritten carry echoes its input
  a_r13_carry_echo: assert property (@(posedge clk) disable iff (rst)
    (live && !c_we_o) |-> (c_o == $past(c_i)));

endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;

  localparam int DIG = 1;
  localparam int W   = 4 * DIG;
  localparam int M   = 1 << W;
  localparam int DM  = 10 ** DIG;
  localparam int PW  = W + 9;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op  = 4'd0;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic         n_i = 1'b0, v_i = 1'b0, z_i = 1'b0, c_i = 1'b0, d_i = 1'b0;
  logic [W-1:0] res_o;
  logic         res_we_o, n_o, v_o, z_o, c_o, n_we_o, v_we_o, z_we_o, c_we_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  acc_alu #(.DIGITS(DIG)) u0 (
    .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b),
    .n_i(n_i), .v_i(v_i), .z_i(z_i), .c_i(c_i), .d_i(d_i),
    .res_o(res_o), .res_we_o(res_we_o),
    .n_o(n_o), .v_o(v_o), .z_o(z_o), .c_o(c_o),
    .n_we_o(n_we_o), .v_we_o(v_we_o), .z_we_o(z_we_o), .c_we_o(c_we_o)
  );

  function automatic logic [PW-1:0] observed();
    return {res_we_o, res_o, n_o, v_o, z_o, c_o, n_we_o, v_we_o, z_we_o, c_we_o};
  endfunction

  function automatic int dval(int x);
    int s = 0;
    int p = 1;
    for (int i = 0; i < DIG; i++) begin
      s += ((x >> (4*i)) & 15) * p;
      p *= 10;
    end
    return s;
  endfunction

  function automatic int denc(int x);
    int s = 0;
    int r = x;
    for (int i = 0; i < DIG; i++) begin
      s |= (r % 10) << (4*i);
      r /= 10;
    end
    return s;
  endfunction

  function automatic bit bcd_ok(int x);
    for (int i = 0; i < DIG; i++)
      if (((x >> (4*i)) & 15) > 9) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit msb(int x);
    return bit'((x >> (W-1)) & 1);
  endfunction

  // Expected outputs derived from the requirements
  function automatic logic [PW-1:0] model(int o, int av, int bv, bit n, bit v, bit z, bit c, bit d);
    int r = 0, s, bb, binr, t;
    bit rw = 0, no = n, vo = v, zo = z, co = c;
    bit nw = 0, vw = 0, zw = 0, cw = 0;
    case (o)
      0, 1, 2, 7, 8, 13: begin
        case (o)
          0: r = av | bv;
          1: r = av & bv;
          2: r = av ^ bv;
          7: r = (bv + 1) % M;
          8: r = (bv + M - 1) % M;
          default: r = bv;
        endcase
        rw = 1; nw = 1; zw = 1;
      end
      3, 4: begin
        bb   = (o == 4) ? (M - 1 - bv) : bv;
        s    = av + bb + int'(c);
        binr = s % M;
        vo   = (msb(av) == msb(bb)) && (msb(binr) != msb(av));
        if (!d) begin
          r  = binr;
          co = (s >= M);
        end else if (o == 3) begin
          t  = dval(av) + dval(bv) + int'(c);
          co = (t >= DM);
          r  = denc(t % DM);
        end else begin
          t  = dval(av) - dval(bv) - (1 - int'(c));
          co = (t >= 0);
          r  = denc((t + DM) % DM);
        end
        rw = 1; nw = 1; vw = 1; zw = 1; cw = 1;
      end
      5: begin
        t  = (av - bv + M) % M;
        no = msb(t);
        zo = (av == bv);
        co = (av >= bv);
        nw = 1; zw = 1; cw = 1;
      end
      6: begin
        zo = ((av & bv) == 0);
        no = msb(bv);
        vo = bit'((bv >> (W-2)) & 1);
        nw = 1; vw = 1; zw = 1;
      end
      9, 10, 11, 12: begin
        case (o)
          9:  begin r = (bv << 1) % M;              co = msb(bv); end
          10: begin r = ((bv << 1) | int'(c)) % M;  co = msb(bv); end
          11: begin r = bv >> 1;                    co = bit'(bv & 1); end
          default: begin r = (bv >> 1) | (int'(c) << (W-1)); co = bit'(bv & 1); end
        endcase
        rw = 1; nw = 1; zw = 1; cw = 1;
      end
      default: ;
    endcase
    if (rw) begin
      no = msb(r);
      zo = (r == 0);
    end
    return {rw, W'(r), no, vo, zo, co, nw, vw, zw, cw};
  endfunction

  function automatic string tag_of(int o, bit d);
    case (o)
      0, 1, 2: return "R3";
      3:       return d ? "R6" : "R4";
      4:       return d ? "R6" : "R5";
      5:       return "R7";
      6:       return "R8";
      7, 8:    return "R9";
      9, 10, 11, 12: return "R10";
      13:      return "R11";
      default: return "R13";
    endcase
  endfunction

  task automatic check(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%b expected=%b", tag, op, a, b, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [PW-1:0] e;
    // R1: reset clears outputs even with live inputs
    op = 4'd3; a = 4'h7; b = 4'h9; c_i = 1'b1; n_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1", observed(), '0);
    @(negedge clk) rst = 1'b0;

    // exhaustive sweep
    for (int o = 0; o < 16; o++) begin
      for (int av = 0; av < M; av++) begin
        for (int bv = 0; bv < M; bv++) begin
          for (int cd = 0; cd < 4; cd++) begin
            if (cd >= 2 && (o == 3 || o == 4) && !(bcd_ok(av) && bcd_ok(bv))) continue;
            @(negedge clk);
            op  = 4'(o);
            a   = W'(av);
            b   = W'(bv);
            c_i = cd[0];
            d_i = cd[1];
            n_i = a[1];
            v_i = b[0];
            z_i = a[0] ^ b[W-1];
            e = model(o, av, bv, n_i, v_i, z_i, c_i, d_i);
            @(posedge clk);
            #1;
            check(tag_of(o, d_i), observed(), e);
            if (res_we_o)  // R12: N/Z follow the written result
              check("R12", {n_o, z_o}, {res_o[W-1], res_o == '0});
          end
        end
      end
    end

    // R2: one-cycle latency, outputs hold until the edge
    @(negedge clk);
    op = 4'd3; a = 4'h3; b = 4'h4; c_i = 1'b0; d_i = 1'b0;
    @(posedge clk);
    #1 check("R2", {res_we_o, res_o}, {1'b1, 4'h7});
    @(negedge clk);
    op = 4'd0; a = 4'h5; b = 4'h8;
    #1 check("R2", {res_we_o, res_o}, {1'b1, 4'h7});
    @(posedge clk);
    #1 check("R2", {res_we_o, res_o}, {1'b1, 4'hD});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule